// File: doc/BRIEF.md
# Ring Oscillator Response Bit Evaluator

This block turns the frequency mismatch between on-chip ring oscillators into one response bit. Each oscillator output arrives as an asynchronous pulse train. It is brought into the system clock domain, and its rising edges are counted during a timed measurement window. When the window closes, the counts are compared. The oscillator that completed more cycles is the faster one, and the bit records which oscillator won.

A pair whose counts lie too close together is unreliable, because temperature or supply drift could flip it. Such a pair is flagged as unusable through a programmable threshold. In group mode the block looks at all of its oscillators. It takes the fastest and the slowest as the compared pair, which gives the widest gap, and reports their indices so that the caller can store them as helper data.

A run is controlled by a small state machine with three states. ST_IDLE waits for a start strobe. ST_COUNT is the open window, during which oscillator edges are counted and a timer counts down. ST_LATCH is a single cycle in which the outcome is captured. The transitions are:
- start moves the machine from any state to ST_COUNT.
- Expiry of the timer moves ST_COUNT to ST_LATCH.
- ST_LATCH always moves to ST_IDLE.

Top module: `ropuf_eval`

## Requirements
- R1: Each ro_in line passes through a two-flop synchronizer. Every rising edge that stays high for at least one clock period is counted exactly once, but only while the machine is in ST_COUNT.
- R2: start clears every counter, loads the window timer and enters ST_COUNT from any state. If start coincides with the ST_LATCH cycle, the result is discarded: resp_valid stays low and the outputs keep their old values.
- R3: After the clock edge that samples start, counting covers the next win_len rising edges, and a win_len of 0 behaves as 1. resp_valid is high for exactly one cycle, starting at the (win_len+1)-th rising edge after the edge that sampled start.
- R4: In pair mode (group_mode = 0), only ro_in[0] (primary) and ro_in[1] are compared.
  - resp_bit is 1 when the count of ro_in[0] is strictly greater than the count of ro_in[1], and 0 otherwise.
  - fast_idx/slow_idx are 0/1 when resp_bit is 1, and 1/0 otherwise.
- R5: resp_usable is 1 only when the absolute difference between the compared counts is greater than or equal to threshold.
- R6: Counters saturate at 2^CNT_W-1 and do not wrap. A counter that has reached that value forces resp_usable to 0.
- R7: In group mode (group_mode = 1), every oscillator takes part in the selection.
  - fast_idx is the index with the largest count and slow_idx the index with the smallest count. On a tie, the lowest index wins in both cases.
  - resp_bit is 1 when fast_idx < slow_idx.
  - The count gap used for the threshold is the fastest count minus the slowest count.
- R8: After reset all outputs are 0. resp_bit, resp_usable, fast_idx and slow_idx change only together with a resp_valid pulse and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts or restarts a measurement |
| group_mode | input | 1 | 0 selects pair mode, 1 selects group mode |
| win_len | input | WIN_W | Window length in system clock cycles |
| threshold | input | CNT_W | Minimum count gap for a usable bit |
| ro_in | input | NUM_RO | Asynchronous oscillator outputs |
| resp_bit | output | 1 | Response bit |
| resp_valid | output | 1 | One-cycle pulse when a result is captured |
| resp_usable | output | 1 | Result passed the threshold and saturation checks |
| fast_idx | output | $clog2(NUM_RO) | Index of the faster oscillator in the compared pair |
| slow_idx | output | $clog2(NUM_RO) | Index of the slower oscillator in the compared pair |

## Verification
A start strobe can arrive in the very cycle the machine spends in ST_LATCH, so the restart and the capture of a result collide. The bench provokes this by watching its own model until the model reaches the capture phase, then raising start for exactly that clock edge. It judges the outcome on every clock: no resp_valid pulse may appear, the previous outputs must hold, and the restarted run, whose counters were cleared, must deliver a result that reflects zero counts. A second overlap, a restart in the middle of an open window after edges have already been counted, is checked the same way.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_LATCH = 2'd2
    } ro_state_t;
endpackage

// File: rtl/ropuf_edge_sync.sv
module ropuf_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // stage 0 and 1 synchronize, stage 2 remembers the prior synchronized value
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], din};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/ropuf_sat_counter.sv
module ropuf_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    assign sat = &cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (inc && !sat) cnt <= cnt + 1'b1;
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clear) |=> sat);
endmodule

// File: rtl/ropuf_select.sv
module ropuf_select #(
    parameter int NUM_RO = 4,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_RO-1:0][CNT_W-1:0] cnts,
    output logic [IDX_W-1:0]             fast_idx,
    output logic [IDX_W-1:0]             slow_idx,
    output logic [CNT_W-1:0]             fast_cnt,
    output logic [CNT_W-1:0]             slow_cnt
);
    always_comb begin
        fast_idx = '0;
        slow_idx = '0;
        fast_cnt = cnts[0];
        slow_cnt = cnts[0];
        for (int i = 1; i < NUM_RO; i++) begin
            if (cnts[i] > fast_cnt) begin
                fast_cnt = cnts[i];
                fast_idx = IDX_W'(i);
            end
            if (cnts[i] < slow_cnt) begin
                slow_cnt = cnts[i];
                slow_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ropuf_eval.sv
module ropuf_eval #(
    parameter int NUM_RO = 4,
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 20,
    localparam int IDX_W = (NUM_RO > 2) ? $clog2(NUM_RO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              group_mode,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [CNT_W-1:0]  threshold,
    input  logic [NUM_RO-1:0] ro_in,
    output logic              resp_bit,
    output logic              resp_valid,
    output logic              resp_usable,
    output logic [IDX_W-1:0]  fast_idx,
    output logic [IDX_W-1:0]  slow_idx
);
    import ropuf_pkg::*;

    ro_state_t                   state, state_nx;
    logic [WIN_W-1:0]            timer;
    logic [NUM_RO-1:0]           rise, sat;
    logic [NUM_RO-1:0][CNT_W-1:0] cnts;
    logic                        counting, timer_last, capture;

    assign counting   = (state == ST_COUNT);
    assign timer_last = (timer <= WIN_W'(1));
    assign capture    = (state == ST_LATCH) && !start;

    // per-oscillator synchronizer and saturating counter
    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
        ropuf_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ro_in[g]),
            .rise (rise[g])
        );
        ropuf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(start),
            .inc  (rise[g] && counting),
            .cnt  (cnts[g]),
            .sat  (sat[g])
        );
    end

    // window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       timer <= '0;
        else if (start)                   timer <= win_len;
        else if (counting && !timer_last) timer <= timer - 1'b1;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_IDLE;
            ST_COUNT: if (timer_last) state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
        if (start) state_nx = ST_COUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // comparison
    logic [IDX_W-1:0] g_fast, g_slow;
    logic [CNT_W-1:0] g_fcnt, g_scnt;

    ropuf_select #(.NUM_RO(NUM_RO), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sel (
        .cnts    (cnts),
        .fast_idx(g_fast),
        .slow_idx(g_slow),
        .fast_cnt(g_fcnt),
        .slow_cnt(g_scnt)
    );

    logic             r_bit, r_usable;
    logic [IDX_W-1:0] r_fast, r_slow;
    logic [CNT_W-1:0] hi_cnt, lo_cnt, gap;

    always_comb begin
        if (group_mode) begin
            r_bit  = (g_fast < g_slow);
            r_fast = g_fast;
            r_slow = g_slow;
            hi_cnt = g_fcnt;
            lo_cnt = g_scnt;
        end else begin
            r_bit  = (cnts[0] > cnts[1]);
            r_fast = r_bit ? IDX_W'(0) : IDX_W'(1);
            r_slow = r_bit ? IDX_W'(1) : IDX_W'(0);
            hi_cnt = r_bit ? cnts[0] : cnts[1];
            lo_cnt = r_bit ? cnts[1] : cnts[0];
        end
        gap      = hi_cnt - lo_cnt;
        r_usable = !(|sat) && (gap >= threshold);
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_bit    <= 1'b0;
            resp_usable <= 1'b0;
            fast_idx    <= '0;
            slow_idx    <= '0;
        end else begin
            resp_valid <= capture;
            if (capture) begin
                resp_bit    <= r_bit;
                resp_usable <= r_usable;
                fast_idx    <= r_fast;
                slow_idx    <= r_slow;
            end
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_COUNT && !resp_valid));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> ($stable(resp_bit) && $stable(resp_usable)
                         && $stable(fast_idx) && $stable(slow_idx)));

    // R3
    valid_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> ($past(state) == ST_LATCH));
endmodule

// File: tb/tb_ropuf_eval.sv
module tb_ropuf_eval;
    localparam int NRO  = 4;
    localparam int CW   = 6;
    localparam int WW   = 10;
    localparam int SATV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          group_mode = 1'b0;
    logic [WW-1:0] win_len = '0;
    logic [CW-1:0] threshold = '0;
    logic [NRO-1:0] ro_in = '0;
    logic          resp_bit, resp_valid, resp_usable;
    logic [1:0]    fast_idx, slow_idx;

    ropuf_eval #(.NUM_RO(NRO), .CNT_W(CW), .WIN_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .group_mode(group_mode),
        .win_len(win_len), .threshold(threshold), .ro_in(ro_in),
        .resp_bit(resp_bit), .resp_valid(resp_valid), .resp_usable(resp_usable),
        .fast_idx(fast_idx), .slow_idx(slow_idx)
    );

    always #10 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R8";
    bit    checking = 1'b0;

    // reference model state
    int exp_n [NRO];
    int m_phase = 0;
    int m_left = 0;
    bit m_valid = 0, m_bit = 0, m_usable = 0;
    int m_fast = 0, m_slow = 0;

    task automatic model_result();
        int c [NRO];
        bit anysat;
        int fi, si, diff;
        anysat = 0;
        for (int i = 0; i < NRO; i++) begin
            c[i] = (exp_n[i] > SATV) ? SATV : exp_n[i];
            if (c[i] == SATV) anysat = 1;
        end
        if (group_mode) begin
            fi = 0; si = 0;
            for (int i = 1; i < NRO; i++) begin
                if (c[i] > c[fi]) fi = i;
                if (c[i] < c[si]) si = i;
            end
            m_bit = (fi < si);
            diff = c[fi] - c[si];
        end else begin
            m_bit = (c[0] > c[1]);
            fi = m_bit ? 0 : 1;
            si = m_bit ? 1 : 0;
            diff = (c[0] > c[1]) ? c[0] - c[1] : c[1] - c[0];
        end
        m_fast = fi;
        m_slow = si;
        m_usable = !anysat && (diff >= int'(threshold));
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_valid = 0; m_bit = 0; m_usable = 0; m_fast = 0; m_slow = 0;
        end else begin
            m_valid = 0;
            if (start) begin
                m_left = (win_len == 0) ? 1 : int'(win_len);
                m_phase = 1;
            end else if (m_phase == 1) begin
                m_left = m_left - 1;
                if (m_left == 0) m_phase = 2;
            end else if (m_phase == 2) begin
                m_valid = 1;
                m_phase = 0;
                model_result();
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            vectors++;
            cmp("resp_valid", int'(resp_valid), int'(m_valid));
            cmp("resp_bit", int'(resp_bit), int'(m_bit));
            cmp("resp_usable", int'(resp_usable), int'(m_usable));
            cmp("fast_idx", int'(fast_idx), m_fast);
            cmp("slow_idx", int'(slow_idx), m_slow);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_case(string req, int n0, int n1, int n2, int n3, bit gm, int thr);
        int mx, span;
        cur_req = req;
        exp_n[0] = n0; exp_n[1] = n1; exp_n[2] = n2; exp_n[3] = n3;
        mx = 0;
        for (int i = 0; i < NRO; i++) if (exp_n[i] > mx) mx = exp_n[i];
        span = 2 * mx;
        group_mode = gm;
        threshold = CW'(thr);
        win_len = WW'(span + 8);
        pulse_start();
        for (int c = 0; c < span; c++) begin
            for (int i = 0; i < NRO; i++)
                ro_in[i] = ((c % 2) == 0) && ((c / 2) < exp_n[i]);
            @(negedge clk);
        end
        ro_in = '0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NRO; i++) exp_n[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        // R8: reset state is compared on every clock by the model
        repeat (3) @(negedge clk);

        run_case("R4", 9, 4, 0, 0, 1'b0, 2);     // primary faster, R1 edge counts
        run_case("R4", 3, 11, 0, 0, 1'b0, 2);    // second faster
        run_case("R4", 7, 7, 0, 0, 1'b0, 0);     // tie gives 0
        run_case("R1", 4, 2, 20, 13, 1'b0, 1);   // other lines ignored in pair mode
        run_case("R5", 10, 6, 0, 0, 1'b0, 4);    // gap equals threshold: usable
        run_case("R5", 10, 6, 0, 0, 1'b0, 5);    // gap below threshold: rejected
        run_case("R6", 70, 5, 0, 0, 1'b0, 1);    // saturation forces unusable
        run_case("R7", 5, 12, 3, 8, 1'b1, 2);    // group max/min
        run_case("R7", 2, 9, 4, 9, 1'b1, 2);     // tie on max picks lowest index
        run_case("R7", 6, 6, 6, 6, 1'b1, 1);     // all equal, rejected

        // R3: zero window length behaves as one cycle
        cur_req = "R3";
        for (int i = 0; i < NRO; i++) exp_n[i] = 0;
        group_mode = 1'b0; threshold = '0; win_len = '0;
        pulse_start();
        repeat (10) @(negedge clk);

        // R2: restart in the middle of a window after edges were counted
        cur_req = "R2";
        threshold = CW'(1); win_len = WW'(40);
        pulse_start();
        for (int c = 0; c < 10; c++) begin
            ro_in[0] = (c % 2) == 0;
            @(negedge clk);
        end
        ro_in = '0;
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (50) @(negedge clk);

        // R2: start collides with the capture cycle
        cur_req = "R2";
        run_case("R2", 8, 1, 0, 0, 1'b0, 0);
        for (int i = 0; i < NRO; i++) exp_n[i] = 0;
        threshold = CW'(1); win_len = WW'(12);
        pulse_start();
        while (m_phase != 2) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (25) @(negedge clk);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule